// File: doc/BRIEF.md
# Edge/Level Interrupt Controller (single bank)

This block collects up to 32 interrupt request lines and presents them to a processor as two interrupt outputs: a normal request and a fast request. Each line has a configuration register that selects whether the line latches on a rising edge or follows an active level. The same register routes the line to one of the two outputs and gives it a priority. Latched requests are held in a pending register and gated by a mask register. For each output class, a priority arbiter picks one winning line.

Each output works as a one-shot under software control. When the output is armed and an unmasked pending line of its class exists, the output goes high. At that moment it captures the winning line number into a source-index register and disarms itself. Reading the source-index register acknowledges the winning line if that line is edge-sensitive. The output stays high until software writes the matching control bit, which drops the output and re-arms it. A software-trigger register lets firmware raise a request on any line.

Register accesses are 32-bit, word-aligned and single-cycle. Read data is registered and valid in the cycle after the request.

Top module: `intc_bank`

## Requirements
- R1: After reset the mask register (offset 0x00 is pending, 0x04 is mask) reads 0xFFFFFFFF. Pending, every line configuration and both source indices read 0, and both outputs are low.
- R2: The configuration register of line n is at offset 0x1C+4n. It holds the priority in bits [6:2], the level-sensitive flag in bit 1 (0 = edge, 1 = level) and the fast-class route in bit 0 (0 = normal, 1 = fast). A read returns the same packing with all other bits 0.
- R3: An edge line sets its pending bit on a 0-to-1 change of its input. The bit stays set after the input falls.
- R4: A level line sets its pending bit when its input rises. The bit clears when the input falls.
- R5: A write to offset 0x00 clears every pending bit written as 0 and keeps every bit written as 1. A level line whose input is still high keeps its pending bit.
- R6: Within a class, the winner is the unmasked pending line with the numerically lowest priority. Among equal priorities, the higher-numbered line wins.
- R7: An armed output goes high on the clock edge after an unmasked pending line of its class exists. It then captures the winner and disarms. Writing offset 0x18 with bit 0 (normal) or bit 1 (fast) set drives that output low in the next cycle and re-arms it. The output then rises one edge later if a request remains.
- R8: A read of offset 0x10 (normal) or 0x14 (fast) returns the captured line number. If that line is edge-sensitive, the read clears its pending bit; a level line's pending bit is unaffected. Writes to these offsets are ignored.
- R9: A mask bit of 1 keeps its line from asserting an output, while the line's pending bit still latches.
- R10: A write to offset 0x9C sets the pending bit of only the lowest-numbered 1 bit of the written value. The offset reads 0.
- R11: The control offset 0x18 reads 0. An unmapped offset (for example 0x0C) reads 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | NUM_LINES | Interrupt request inputs, active high, synchronous to clk_i |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Normal-class interrupt output |
| fiq_o | output | 1 | Fast-class interrupt output |

## Verification
The configuration registers are swept over all 32 lines with distinct packings and junk in the upper bits. This separates field placement from field masking. Input sensing is tried with rising, held and falling inputs on an edge line and a level line side by side, then against pending-register writes with the input high and low. This tells the edge rules apart from the level rules and shows that the write protection applies only to level lines. The arbiter is drained line by line from a full pending set, once with many tied priorities on the normal class, and once with interleaved normal and fast lines under reversed priorities. This separates the tie rule, the class routing and the acknowledge-on-read. A mixed scenario of masking, re-arming and level versus edge acknowledge pins the output handshake timing.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int OFF_PEND      = 'h00;
  localparam int OFF_MASK      = 'h04;
  localparam int OFF_SRC_IRQ   = 'h10;
  localparam int OFF_SRC_FIQ   = 'h14;
  localparam int OFF_CTRL      = 'h18;
  localparam int OFF_LINE_BASE = 'h1C;
  localparam int NUM_CLASSES   = 2;  // 0 = normal, 1 = fast

  typedef enum logic [0:0] {
    CLS_IRQ = 1'b0,
    CLS_FIQ = 1'b1
  } int_class_e;
endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] in_i,
  input  logic [NUM_LINES-1:0] level_i,
  input  logic [NUM_LINES-1:0] sw_set_i,
  input  logic                 wr_en_i,
  input  logic [NUM_LINES-1:0] wr_keep_i,
  input  logic [NUM_LINES-1:0] ack_i,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] in_prev_q, pend_q, rise, fall_lvl, set_v, wr_clr, pend_d;

  assign rise     = in_i & ~in_prev_q;
  assign fall_lvl = level_i & in_prev_q & ~in_i;
  assign set_v    = rise | sw_set_i;
  // active level lines are protected against software clear
  assign wr_clr   = wr_en_i ? ~(wr_keep_i | (in_i & level_i)) : '0;
  assign pend_d   = (pend_q | set_v) & ~fall_lvl & ~wr_clr & ~ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_prev_q <= '0;
      pend_q    <= '0;
    end else begin
      in_prev_q <= in_i;
      pend_q    <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R3: an edge line's pending bit only drops through a write or an acknowledge
  a_r3_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~$past(level_i) & $past(pend_q) & ~pend_q & ~$past(wr_clr | ack_i)) == '0));
  // R4: a falling level input leaves no pending bit unless a new set arrives
  a_r4_level_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(fall_lvl & ~set_v) & pend_q) == '0));
  // R5: level line with active input survives a pending write
  a_r5_level_protect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (($past(level_i & in_i & in_prev_q & pend_q) & ~pend_q) == '0));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 5,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]             req_i,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_i,
  output logic                             any_o,
  output logic [IDX_W-1:0]                 idx_o
);
  logic [PRIO_W:0] best_p;

  // ascending scan with <= gives ties to the higher-numbered line
  always_comb begin
    best_p = {1'b1, {PRIO_W{1'b0}}};
    idx_o  = '0;
    any_o  = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req_i[i] && ({1'b0, prio_i[i]} <= best_p)) begin
        best_p = {1'b0, prio_i[i]};
        idx_o  = IDX_W'(i);
        any_o  = 1'b1;
      end
    end
    // R6: the winner is a requesting line
    if (any_o) a_r6_winner_valid: assert (req_i[idx_o]);
  end
endmodule

// File: rtl/intc_out_ctl.sv
module intc_out_ctl #(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rearm_i,
  input  logic             any_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             int_o,
  output logic [IDX_W-1:0] src_o
);
  logic armed_q, int_q;
  logic [IDX_W-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      int_q   <= 1'b0;
      src_q   <= '0;
    end else if (rearm_i) begin
      armed_q <= 1'b1;
      int_q   <= 1'b0;
    end else if (armed_q && any_i) begin
      armed_q <= 1'b0;
      int_q   <= 1'b1;
      src_q   <= idx_i;
    end
  end

  assign int_o = int_q;
  assign src_o = src_q;

  a_r7_rearm_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> !int_o);
  a_r7_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o && !rearm_i) |=> int_o);
  a_r7_rise_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_o) |-> $past(any_i));
  a_r8_src_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(int_o) |-> $stable(src_o));
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 5,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 irq_o,
  output logic                 fiq_o
);
  localparam int IDX_W   = $clog2(NUM_LINES);
  localparam int OFF_SWS = OFF_LINE_BASE + 4 * NUM_LINES;

  logic wr, rd, aligned, line_hit;
  logic [ADDR_W-1:0] line_off;
  logic [IDX_W-1:0]  line_idx;

  logic [NUM_LINES-1:0]             mask_q, level_q, fiq_q, pend;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_LINES-1:0]             sw_set, ack, wvec;
  logic [DATA_W-1:0]                rd_val, rdata_q;

  logic [NUM_CLASSES-1:0]            any_w, int_w, rearm_w;
  logic [NUM_CLASSES-1:0][IDX_W-1:0] idx_w, src_w;

  assign wr       = bus_req_i & bus_we_i;
  assign rd       = bus_req_i & ~bus_we_i;
  assign aligned  = (bus_addr_i[1:0] == 2'b00);
  assign line_off = bus_addr_i - ADDR_W'(OFF_LINE_BASE);
  assign line_idx = IDX_W'(line_off >> 2);
  assign line_hit = aligned && (int'(bus_addr_i) >= OFF_LINE_BASE) && (int'(bus_addr_i) < OFF_SWS);
  assign wvec     = bus_wdata_i[NUM_LINES-1:0];

  // configuration and mask registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      level_q <= '0;
      fiq_q   <= '0;
      prio_q  <= '0;
    end else if (wr) begin
      if (bus_addr_i == ADDR_W'(OFF_MASK)) mask_q <= wvec;
      if (line_hit) begin
        prio_q[line_idx]  <= bus_wdata_i[PRIO_W+1:2];
        level_q[line_idx] <= bus_wdata_i[1];
        fiq_q[line_idx]   <= bus_wdata_i[0];
      end
    end
  end

  // software trigger: lowest set bit only
  assign sw_set = (wr && bus_addr_i == ADDR_W'(OFF_SWS)) ? (wvec & (~wvec + 1'b1)) : '0;

  // acknowledge on source read, edge lines only
  always_comb begin
    ack = '0;
    if (rd && bus_addr_i == ADDR_W'(OFF_SRC_IRQ)) ack = (NUM_LINES'(1) << src_w[CLS_IRQ]) & ~level_q;
    if (rd && bus_addr_i == ADDR_W'(OFF_SRC_FIQ)) ack = (NUM_LINES'(1) << src_w[CLS_FIQ]) & ~level_q;
  end

  intc_pending #(.NUM_LINES(NUM_LINES)) i_pending (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_i      (irq_lines_i),
    .level_i   (level_q),
    .sw_set_i  (sw_set),
    .wr_en_i   (wr && bus_addr_i == ADDR_W'(OFF_PEND)),
    .wr_keep_i (wvec),
    .ack_i     (ack),
    .pend_o    (pend)
  );

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
    logic [NUM_LINES-1:0] req;
    assign req        = pend & ~mask_q & ((c == int'(CLS_FIQ)) ? fiq_q : ~fiq_q);
    assign rearm_w[c] = wr && (bus_addr_i == ADDR_W'(OFF_CTRL)) && bus_wdata_i[c];

    intc_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) i_arbiter (
      .req_i  (req),
      .prio_i (prio_q),
      .any_o  (any_w[c]),
      .idx_o  (idx_w[c])
    );

    intc_out_ctl #(.IDX_W(IDX_W)) i_out_ctl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rearm_i (rearm_w[c]),
      .any_i   (any_w[c]),
      .idx_i   (idx_w[c]),
      .int_o   (int_w[c]),
      .src_o   (src_w[c])
    );

    // R9: an output never rises without an unmasked request of its class
    a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(int_w[c]) |-> ($past(pend & ~mask_q) != '0));
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (line_hit) begin
      rd_val = DATA_W'({prio_q[line_idx], level_q[line_idx], fiq_q[line_idx]});
    end else begin
      case (int'(bus_addr_i))
        OFF_PEND:    rd_val = DATA_W'(pend);
        OFF_MASK:    rd_val = DATA_W'(mask_q);
        OFF_SRC_IRQ: rd_val = DATA_W'(src_w[CLS_IRQ]);
        OFF_SRC_FIQ: rd_val = DATA_W'(src_w[CLS_FIQ]);
        default:     rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = int_w[CLS_IRQ];
  assign fiq_o       = int_w[CLS_FIQ];

  // R10: a software trigger sets at most one line
  a_r10_single_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sw_set));
endmodule

// File: tb/test_intc_bank.sv
module test_intc_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int n_checks = 0, n_fail = 0;
  int m_prio [32];
  logic [31:0] m_pend;
  logic [31:0] v;

  always #5 clk = ~clk;

  intc_bank i_intc_bank (
    .clk_i(clk), .rst_ni(rst_ni), .irq_lines_i(irq_lines),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic do_reset();
    irq_lines = '0;
    @(negedge clk);
    rst_ni = 1'b0;
    tick(2);
    rst_ni = 1'b1;
    tick(1);
  endtask

  function automatic int winner(logic [31:0] r);
    int best = 99, w = 0;
    for (int i = 0; i < 32; i++)
      if (r[i] && m_prio[i] <= best) begin best = m_prio[i]; w = i; end
    return w;
  endfunction

  // drain all pending lines of one class through re-arm and source reads
  task automatic drain(int cls, logic [31:0] cls_lines, string r);
    logic [31:0] d;
    logic [31:0] cur;
    int exp;
    for (int k = 0; k < 32; k++) begin
      cur = m_pend & cls_lines;
      if (cur != 0) begin
        bus_write(8'h18, 32'(1 << cls));
        tick(2);
        chk({r, " output"}, 32'(cls ? fiq : irq), 32'd1);
        exp = winner(cur);
        bus_read(cls ? 8'h14 : 8'h10, d);
        chk({r, " winner"}, d, 32'(exp));
        m_pend[exp] = 1'b0;
      end
    end
    bus_write(8'h18, 32'(1 << cls));
    tick(2);
    chk({r, " drained quiet"}, 32'(cls ? fiq : irq), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    bus_read(8'h00, v); chk("R1 pending", v, 32'h0);
    bus_read(8'h04, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    bus_read(8'h10, v); chk("R1 src irq", v, 32'h0);
    bus_read(8'h14, v); chk("R1 src fiq", v, 32'h0);
    bus_read(8'h1C, v); chk("R1 line0 cfg", v, 32'h0);
    bus_read(8'h98, v); chk("R1 line31 cfg", v, 32'h0);
    chk("R1 outputs", {30'd0, irq, fiq}, 32'h0);

    // R2 sweep over all line registers
    for (int n = 0; n < 32; n++)
      bus_write(8'(8'h1C + 4 * n), 32'hFFFF_FF00 | 32'(((n * 3 + 1) % 32) << 2) | 32'((n % 2) << 1) | 32'((n / 2) % 2));
    for (int n = 0; n < 32; n++) begin
      bus_read(8'(8'h1C + 4 * n), v);
      chk("R2 cfg packing", v, 32'(((n * 3 + 1) % 32) << 2) | 32'((n % 2) << 1) | 32'((n / 2) % 2));
    end

    // R3/R4 sensing: line 3 edge, line 5 level
    do_reset();
    bus_write(8'h1C + 4 * 5, 32'h2);
    irq_lines = 32'h28; tick(2);
    bus_read(8'h00, v); chk("R3 R4 rise sets", v, 32'h28);
    irq_lines = 32'h0; tick(2);
    bus_read(8'h00, v); chk("R3 edge kept R4 level cleared", v, 32'h08);
    // R5 write-clear and level protection
    irq_lines = 32'h20; tick(2);
    bus_read(8'h00, v); chk("R4 level sets again", v, 32'h28);
    bus_write(8'h00, 32'h0);
    bus_read(8'h00, v); chk("R5 edge cleared level protected", v, 32'h20);
    irq_lines = 32'h0; tick(2);
    bus_read(8'h00, v); chk("R4 level falls", v, 32'h0);
    irq_lines = 32'h08; tick(1); irq_lines = 32'h0; tick(1);
    bus_write(8'h00, 32'h08);
    bus_read(8'h00, v); chk("R5 written one kept", v, 32'h08);
    bus_write(8'h00, 32'h0);
    bus_read(8'h00, v); chk("R5 written zero clears", v, 32'h0);
    // R10 software trigger
    bus_write(8'h9C, 32'h50);
    bus_read(8'h00, v); chk("R10 lowest bit only", v, 32'h10);
    bus_read(8'h9C, v); chk("R10 reads zero", v, 32'h0);
    bus_write(8'h00, 32'h0);
    // R11 control and unmapped
    bus_read(8'h18, v); chk("R11 ctrl reads zero", v, 32'h0);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_read(8'h0C, v); chk("R11 unmapped reads zero", v, 32'h0);
    bus_read(8'h04, v); chk("R11 unmapped write no effect mask", v, 32'hFFFF_FFFF);
    bus_read(8'h00, v); chk("R11 unmapped write no effect pending", v, 32'h0);
    chk("R9 mask all ones quiet", {30'd0, irq, fiq}, 32'h0);

    // R7/R8/R9 handshake: 4 edge irq p0, 7 level fiq p2, 9 edge fiq p1
    do_reset();
    bus_write(8'h1C + 4 * 4, 32'h00);
    bus_write(8'h1C + 4 * 7, 32'h0B);
    bus_write(8'h1C + 4 * 9, 32'h05);
    bus_write(8'h04, 32'hFFFF_FD7F);
    irq_lines = 32'h290; tick(3);
    chk("R7 fiq asserts", 32'(fiq), 32'd1);
    chk("R9 masked irq quiet", 32'(irq), 32'd0);
    bus_read(8'h14, v); chk("R6 R8 fiq winner", v, 32'd9);
    bus_read(8'h00, v); chk("R8 edge acked", v, 32'h90);
    chk("R7 held without rearm", 32'(fiq), 32'd1);
    bus_write(8'h18, 32'h2);
    chk("R7 rearm drops", 32'(fiq), 32'd0);
    tick(1);
    chk("R7 reasserts next edge", 32'(fiq), 32'd1);
    bus_read(8'h14, v); chk("R8 level winner", v, 32'd7);
    bus_read(8'h00, v); chk("R8 level not acked", v, 32'h90);
    bus_write(8'h14, 32'h1F);
    bus_read(8'h14, v); chk("R8 src write ignored", v, 32'd7);
    irq_lines = 32'h210; tick(2);
    bus_read(8'h00, v); chk("R4 level drop", v, 32'h10);
    bus_write(8'h18, 32'h2); tick(2);
    chk("R7 no request stays low", 32'(fiq), 32'd0);
    chk("R9 irq still masked", 32'(irq), 32'd0);
    bus_write(8'h04, 32'hFFFF_FFEF); tick(2);
    chk("R9 unmask asserts irq", 32'(irq), 32'd1);
    bus_read(8'h10, v); chk("R8 irq winner", v, 32'd4);
    bus_read(8'h00, v); chk("R8 irq edge acked", v, 32'h0);

    // R6 sweep 1: normal class, many ties
    do_reset();
    for (int n = 0; n < 32; n++) begin
      m_prio[n] = (n * 5) % 8;
      bus_write(8'(8'h1C + 4 * n), 32'(m_prio[n] << 2));
    end
    bus_write(8'h04, 32'h0);
    irq_lines = 32'hFFFF_FFFF; tick(1); irq_lines = 32'h0; tick(2);
    m_pend = 32'hFFFF_FFFF;
    drain(0, 32'hFFFF_FFFF, "R6 tie sweep");
    bus_read(8'h00, v); chk("R6 tie sweep empty", v, 32'h0);

    // R6 sweep 2: interleaved classes, reversed priorities
    do_reset();
    for (int n = 0; n < 32; n++) begin
      m_prio[n] = ((31 - n) % 4) * 3;
      bus_write(8'(8'h1C + 4 * n), 32'(m_prio[n] << 2) | 32'(n % 2));
    end
    bus_write(8'h04, 32'h0);
    irq_lines = 32'hFFFF_FFFF; tick(1); irq_lines = 32'h0; tick(2);
    m_pend = 32'hFFFF_FFFF;
    drain(1, 32'hAAAA_AAAA, "R6 fiq sweep");
    bus_read(8'h00, v); chk("R6 fiq drained irq intact", v, 32'h5555_5555);
    drain(0, 32'h5555_5555, "R6 irq sweep");
    bus_read(8'h00, v); chk("R6 all drained", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule